// File: doc/BRIEF.md
# GPIO Controller with Sticky Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software sets, per pin, whether the input path is open, whether the pin is driven from inside, the level to drive, an inversion of that level, and a pull-up. The controller works out the level actually present on each pin from three candidates. A driver outside the chip comes first. The controller's own output is used when no outside driver is active. The pull-up setting is used when neither drives the pin. The controller then samples that level through the input enable.

Every pin has four interrupt sources: level high, level low, rising edge and falling edge. Each source holds a sticky pending flag and has its own enable bit. Software clears a pending flag by writing a one to it. Each pin drives its own interrupt line and its own output line.

A drive-strength register and two alternate-function registers are kept only as storage and have no effect on the pins. The register bus is a simple one: one 32-bit word per access, writes take effect on the clock edge, and reads are combinational.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is held, every mapped register reads 0, and irq, pin_out and pin_oe are 0.
- R2: pin_oe equals the output-enable register, and pin_out equals output enable AND (port bit XOR inversion bit). Both outputs follow a register write from the clock edge of that write.
- R3: The resolved level of a pin is chosen in this order: pin_in when pin_drv is 1; otherwise the internal output when output enable is 1; otherwise the pull-up bit. The sampled level is the resolved level AND the input enable. Pin inputs pass through one register stage. The value register (offset 0x00) loads the sampled level on every clock, so a pin change is visible two edges later and a configuration write one edge later.
- R4: The high-pending flag sets on every clock where the sampled level is 1, and the low-pending flag sets on every clock where it is 0. Both flags hold until they are cleared.
- R5: The rise-pending flag sets when the sampled level is 1 and the stored value is 0. The fall-pending flag sets when the sampled level is 0 and the stored value is 1.
- R6: A write to a pending register (rise 0x1C, fall 0x24, high 0x2C, low 0x34) clears the bits that are 1 in the data and leaves the bits that are 0 unchanged.
- R7: When a set condition and a clear by write happen in the same clock, the flag stays set.
- R8: irq of a pin is the OR of the four products pending AND enable. The enable registers are rise 0x18, fall 0x20, high 0x28 and low 0x30. irq is combinational from these registers.
- R9: Reads of an unmapped or misaligned byte address return 0, and writes to such an address change nothing. The value register ignores writes.
- R10: Drive strength (0x14), alternate enable (0x38) and alternate select (0x3C) read back the value written and have no effect on pin_out, pin_oe or the value register.
- R11: The read/write registers sit at these byte offsets: input enable 0x04, output enable 0x08, port 0x0C, pull-up 0x10, inversion 0x40, plus the offsets given in R8 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | NPINS | Level applied by an outside driver |
| pin_drv | input | NPINS | 1 where an outside driver is active |
| pin_out | output | NPINS | Internal drive level of each pin |
| pin_oe | output | NPINS | Output enable of each pin |
| irq | output | NPINS | Interrupt line of each pin |

## Verification
Register writes land on the clock edge. The bench therefore checks pin_out, pin_oe and irq half a cycle after the write edge, and reads back registers on the next falling edge. A change on pin_in or pin_drv reaches the value and pending registers after two edges: the input register, then the state update. The bench waits exactly two rising edges after each pin change before it reads. After a configuration write it waits one extra edge before reading the value register. The same-cycle clear-versus-set case is read half a cycle after the clearing edge, so that no further set edge can mask a wrong result.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int BUS_W     = 32;
  localparam int NUM_KINDS = 4;
  localparam int KIND_RISE = 0;
  localparam int KIND_FALL = 1;
  localparam int KIND_HIGH = 2;
  localparam int KIND_LOW  = 3;
  localparam int LAST_IDX  = 16;

  // word index = byte offset / 4
  typedef enum logic [4:0] {
    REG_VALUE     = 5'd0,
    REG_IEN       = 5'd1,
    REG_OEN       = 5'd2,
    REG_PORT      = 5'd3,
    REG_PULL      = 5'd4,
    REG_DRIVE     = 5'd5,
    REG_RISE_EN   = 5'd6,
    REG_RISE_PEND = 5'd7,
    REG_FALL_EN   = 5'd8,
    REG_FALL_PEND = 5'd9,
    REG_HIGH_EN   = 5'd10,
    REG_HIGH_PEND = 5'd11,
    REG_LOW_EN    = 5'd12,
    REG_LOW_PEND  = 5'd13,
    REG_ALT_EN    = 5'd14,
    REG_ALT_SEL   = 5'd15,
    REG_INVERT    = 5'd16
  } reg_idx_e;

  function automatic reg_idx_e en_reg(input int kind);
    case (kind)
      KIND_RISE: return REG_RISE_EN;
      KIND_FALL: return REG_FALL_EN;
      KIND_HIGH: return REG_HIGH_EN;
      default:   return REG_LOW_EN;
    endcase
  endfunction

  function automatic reg_idx_e pend_reg(input int kind);
    case (kind)
      KIND_RISE: return REG_RISE_PEND;
      KIND_FALL: return REG_FALL_PEND;
      KIND_HIGH: return REG_HIGH_PEND;
      default:   return REG_LOW_PEND;
    endcase
  endfunction

  // level the controller itself puts on a pin
  function automatic logic pin_drive(input logic oe, input logic port, input logic inv);
    return oe & (port ^ inv);
  endfunction

  // outside driver first, then own drive, then pull-up
  function automatic logic pin_level(input logic ext_on, input logic ext_val,
                                     input logic oe, input logic own_val,
                                     input logic pull);
    if (ext_on)  return ext_val;
    if (oe)      return own_val;
    return pull;
  endfunction

  function automatic logic pin_event(input int kind, input logic cur, input logic prev);
    case (kind)
      KIND_RISE: return cur & ~prev;
      KIND_FALL: return ~cur & prev;
      KIND_HIGH: return cur;
      default:   return ~cur;
    endcase
  endfunction

  // a set in the same cycle beats a clear
  function automatic logic sticky_next(input logic pend, input logic set, input logic clr);
    return set | (pend & ~clr);
  endfunction

  function automatic logic pin_irq(input logic [NUM_KINDS-1:0] pend,
                                   input logic [NUM_KINDS-1:0] en);
    return |(pend & en);
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_en,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [BUS_W-1:0]                  bus_wdata,
  output logic [BUS_W-1:0]                  bus_rdata,
  input  logic [NPINS-1:0]                  value_i,
  input  logic [NUM_KINDS-1:0][NPINS-1:0]   pend_i,
  output logic [NPINS-1:0]                  ien_o,
  output logic [NPINS-1:0]                  oen_o,
  output logic [NPINS-1:0]                  port_o,
  output logic [NPINS-1:0]                  pull_o,
  output logic [NPINS-1:0]                  inv_o,
  output logic [NUM_KINDS-1:0][NPINS-1:0]   en_o,
  output logic [NUM_KINDS-1:0][NPINS-1:0]   clr_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             hit;
  logic             wr;
  reg_idx_e         sel;
  logic [NPINS-1:0] wbits;

  logic [NPINS-1:0] ien_q, oen_q, port_q, pull_q, inv_q;
  logic [NPINS-1:0] drive_q, alt_en_q, alt_sel_q;
  logic [NUM_KINDS-1:0][NPINS-1:0] en_q;
  logic [BUS_W-1:0] rd;

  assign widx  = bus_addr[ADDR_W-1:2];
  assign hit   = (bus_addr[1:0] == 2'b00) && (widx <= IDX_W'(LAST_IDX));
  assign sel   = reg_idx_e'(widx[4:0]);
  assign wr    = bus_en && bus_we && hit;
  assign wbits = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      oen_q     <= '0;
      port_q    <= '0;
      pull_q    <= '0;
      inv_q     <= '0;
      drive_q   <= '0;
      alt_en_q  <= '0;
      alt_sel_q <= '0;
      en_q      <= '0;
    end else if (wr) begin
      case (sel)
        REG_IEN:     ien_q     <= wbits;
        REG_OEN:     oen_q     <= wbits;
        REG_PORT:    port_q    <= wbits;
        REG_PULL:    pull_q    <= wbits;
        REG_INVERT:  inv_q     <= wbits;
        REG_DRIVE:   drive_q   <= wbits;
        REG_ALT_EN:  alt_en_q  <= wbits;
        REG_ALT_SEL: alt_sel_q <= wbits;
        default: ;
      endcase
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (sel == en_reg(k)) en_q[k] <= wbits;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_KINDS; k++) begin
      clr_o[k] = (wr && sel == pend_reg(k)) ? wbits : '0;
    end
  end

  always_comb begin
    rd = '0;
    if (hit) begin
      case (sel)
        REG_VALUE:   rd[NPINS-1:0] = value_i;
        REG_IEN:     rd[NPINS-1:0] = ien_q;
        REG_OEN:     rd[NPINS-1:0] = oen_q;
        REG_PORT:    rd[NPINS-1:0] = port_q;
        REG_PULL:    rd[NPINS-1:0] = pull_q;
        REG_INVERT:  rd[NPINS-1:0] = inv_q;
        REG_DRIVE:   rd[NPINS-1:0] = drive_q;
        REG_ALT_EN:  rd[NPINS-1:0] = alt_en_q;
        REG_ALT_SEL: rd[NPINS-1:0] = alt_sel_q;
        default: ;
      endcase
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (sel == en_reg(k))   rd[NPINS-1:0] = en_q[k];
        if (sel == pend_reg(k)) rd[NPINS-1:0] = pend_i[k];
      end
    end
  end

  assign bus_rdata = rd;
  assign ien_o     = ien_q;
  assign oen_o     = oen_q;
  assign port_o    = port_q;
  assign pull_o    = pull_q;
  assign inv_o     = inv_q;
  assign en_o      = en_q;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> bus_rdata == '0);

endmodule

// File: rtl/gpio_sampler.sv
module gpio_sampler
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NPINS-1:0]                pin_in,
  input  logic [NPINS-1:0]                pin_drv,
  input  logic [NPINS-1:0]                ien_i,
  input  logic [NPINS-1:0]                oen_i,
  input  logic [NPINS-1:0]                port_i,
  input  logic [NPINS-1:0]                pull_i,
  input  logic [NPINS-1:0]                inv_i,
  output logic [NPINS-1:0]                drive_o,
  output logic [NPINS-1:0]                sample_o,
  output logic [NPINS-1:0]                value_o,
  output logic [NUM_KINDS-1:0][NPINS-1:0] ev_o
);

  logic [NPINS-1:0] in_q, drv_q, value_q, level;
  logic             up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      drv_q   <= '0;
      value_q <= '0;
      up_q    <= 1'b0;
    end else begin
      in_q    <= pin_in;
      drv_q   <= pin_drv;
      value_q <= sample_o;
      up_q    <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign drive_o[i]  = pin_drive(oen_i[i], port_i[i], inv_i[i]);
    assign level[i]    = pin_level(drv_q[i], in_q[i], oen_i[i], drive_o[i], pull_i[i]);
    assign sample_o[i] = ien_i[i] & level[i];
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      assign ev_o[k][i] = pin_event(k, sample_o[i], value_q[i]);
    end
  end

  assign value_o = value_q;

  // R3
  value_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> value_q == $past(sample_o));

endmodule

// File: rtl/gpio_sticky.sv
module gpio_sticky
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] pend_o
);

  logic [NPINS-1:0] pend_q, pend_d;
  logic             up_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    assign pend_d[i] = sticky_next(pend_q[i], set_i[i], clr_i[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      up_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      up_q   <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R4
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (~pend_q & $past(pend_q) & ~$past(clr_i)) == '0);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> ($past(clr_i) & ~$past(set_i) & pend_q) == '0);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> ($past(set_i) & ~pend_q) == '0);

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pin_drv,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  irq
);

  logic [NPINS-1:0] ien, oen, port, pull, inv, sample, value;
  logic [NUM_KINDS-1:0][NPINS-1:0] en, clr, ev, pend;
  logic up_q;

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .value_i(value), .pend_i(pend),
    .ien_o(ien), .oen_o(oen), .port_o(port), .pull_o(pull), .inv_o(inv),
    .en_o(en), .clr_o(clr)
  );

  gpio_sampler #(.NPINS(NPINS)) u_sampler (
    .clk, .rst_n, .pin_in, .pin_drv,
    .ien_i(ien), .oen_i(oen), .port_i(port), .pull_i(pull), .inv_i(inv),
    .drive_o(pin_out), .sample_o(sample), .value_o(value), .ev_o(ev)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_src
    gpio_sticky #(.NPINS(NPINS)) u_sticky (
      .clk, .rst_n, .set_i(ev[k]), .clr_i(clr[k]), .pend_o(pend[k])
    );
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_irq
    logic [NUM_KINDS-1:0] pv, evn;
    always_comb begin
      for (int k = 0; k < NUM_KINDS; k++) begin
        pv[k]  = pend[k][i];
        evn[k] = en[k][i];
      end
    end
    assign irq[i] = pin_irq(pv, evn);
  end

  assign pin_oe = oen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  // R5
  rise_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (pend[KIND_RISE] & ~$past(pend[KIND_RISE]) & ~$past(sample & ~value)) == '0);

  // R5
  fall_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (pend[KIND_FALL] & ~$past(pend[KIND_FALL]) & ~$past(~sample & value)) == '0);

  // R8
  irq_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> irq == '0);

endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;

  localparam int NPINS  = 32;
  localparam int ADDR_W = 8;
  localparam int WATCHDOG_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pin_in = '0;
  logic [NPINS-1:0]  pin_drv = '0;
  logic [NPINS-1:0]  pin_out, pin_oe, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dut (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .pin_in, .pin_drv, .pin_out, .pin_oe, .irq
  );

  typedef struct packed {
    logic [31:0] ien, oen, port, inv, pull, drv, pin, exp_val, exp_out;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'h0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_FFFF, 32'h0, 32'h0, 32'h0, 32'h1234_A987, 32'h1234_A987},
    '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'hF0F0_0F0F, 32'h0, 32'h0, 32'hF0F0_0F0F, 32'h0},
    '{32'hFF00_FF00, 32'h0, 32'h0, 32'h0, 32'hF0F0_0F0F, 32'h0, 32'h0, 32'hF000_0F00, 32'h0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0, 32'h0, 32'h0000_FFFF, 32'h0000_1234, 32'hFFFF_1234, 32'hFFFF_0000},
    '{32'hFFFF_FFFF, 32'h00FF_0000, 32'h00F0_0000, 32'h000F_0000, 32'h0000_FFFF, 32'hFF00_0000, 32'h0F00_0000, 32'h0FFF_FFFF, 32'h00FF_0000},
    '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0},
    '{32'hFFFF_FFFF, 32'h0000_00FF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_00FF, 32'h0000_00FF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr;
    #1;
    data = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] got;
    rd(addr, got);
    check(req, got, exp);
  endtask

  task automatic set_pins(input logic [31:0] drv, input logic [31:0] val);
    @(negedge clk);
    pin_drv = drv; pin_in = val;
  endtask

  function automatic logic [31:0] map_pat(input logic [7:0] off);
    return 32'h5A5A_5A5A ^ {4{off}};
  endfunction

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    // R1: reset state
    repeat (3) @(posedge clk);
    for (int i = 0; i <= 16; i++) begin
      rd(8'(i * 4), got);
      check("R1 reset register", got, 32'h0);
    end
    check("R1 reset irq", irq, 32'h0);
    check("R1 reset pin_out", pin_out, 32'h0);
    check("R1 reset pin_oe", pin_oe, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd_check("R4 low pending after reset", 8'h34, 32'hFFFF_FFFF);
    rd_check("R4 high pending idle", 8'h2C, 32'h0);

    // R2 / R3: resolution table
    for (int v = 0; v < 8; v++) begin
      set_pins(VECS[v].drv, VECS[v].pin);
      wr(8'h04, VECS[v].ien);
      wr(8'h08, VECS[v].oen);
      wr(8'h0C, VECS[v].port);
      wr(8'h40, VECS[v].inv);
      wr(8'h10, VECS[v].pull);
      check("R2 pin_out", pin_out, VECS[v].exp_out);
      check("R2 pin_oe", pin_oe, VECS[v].oen);
      @(posedge clk);
      rd_check("R3 value", 8'h00, VECS[v].exp_val);
    end

    // pending flags
    set_pins(32'hFFFF_FFFF, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h10, 32'h0);
    repeat (3) @(posedge clk);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    rd_check("R7 low set beats clear", 8'h34, 32'hFFFF_FFFF);
    rd_check("R6 rise cleared", 8'h1C, 32'h0);
    rd_check("R6 fall cleared", 8'h24, 32'h0);
    rd_check("R6 high cleared", 8'h2C, 32'h0);

    wr(8'h00, 32'hFFFF_FFFF);
    @(posedge clk);
    rd_check("R9 value ignores write", 8'h00, 32'h0);

    set_pins(32'hFFFF_FFFF, 32'h0000_00F0);
    repeat (2) @(posedge clk);
    rd_check("R3 value after pin rise", 8'h00, 32'h0000_00F0);
    rd_check("R5 rise pending", 8'h1C, 32'h0000_00F0);
    rd_check("R5 no fall yet", 8'h24, 32'h0);
    rd_check("R4 high pending", 8'h2C, 32'h0000_00F0);

    set_pins(32'hFFFF_FFFF, 32'h0);
    repeat (2) @(posedge clk);
    rd_check("R5 fall pending", 8'h24, 32'h0000_00F0);
    rd_check("R4 rise stays sticky", 8'h1C, 32'h0000_00F0);
    rd_check("R4 high stays sticky", 8'h2C, 32'h0000_00F0);
    rd_check("R3 value back low", 8'h00, 32'h0);

    wr(8'h1C, 32'h0000_0030);
    rd_check("R6 partial clear", 8'h1C, 32'h0000_00C0);

    // R8: interrupt combine, one enable at a time
    wr(8'h18, 32'h0000_0040);
    check("R8 irq from rise", irq, 32'h0000_0040);
    wr(8'h18, 32'h0);
    wr(8'h20, 32'h0000_0100);
    check("R8 irq fall enabled, none pending", irq, 32'h0);
    wr(8'h20, 32'h0000_0010);
    check("R8 irq from fall", irq, 32'h0000_0010);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h0000_0020);
    check("R8 irq from high", irq, 32'h0000_0020);
    wr(8'h28, 32'h0);
    wr(8'h30, 32'h0000_0001);
    check("R8 irq from low", irq, 32'h0000_0001);
    wr(8'h30, 32'h0);
    check("R8 irq all disabled", irq, 32'h0);

    // R10: storage-only registers
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h38, 32'h1357_9BDF);
    wr(8'h3C, 32'h2468_ACE0);
    rd_check("R10 drive strength", 8'h14, 32'hDEAD_BEEF);
    rd_check("R10 alt enable", 8'h38, 32'h1357_9BDF);
    rd_check("R10 alt select", 8'h3C, 32'h2468_ACE0);
    check("R10 pin_out untouched", pin_out, 32'h0);
    check("R10 pin_oe untouched", pin_oe, 32'h0);
    rd_check("R10 value untouched", 8'h00, 32'h0);

    // R11: register map
    begin
      logic [7:0] offs [12] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                8'h20, 8'h28, 8'h30, 8'h38, 8'h3C, 8'h40};
      for (int j = 0; j < 12; j++) wr(offs[j], map_pat(offs[j]));
      for (int j = 0; j < 12; j++) rd_check("R11 map readback", offs[j], map_pat(offs[j]));
    end

    // R9: unmapped and misaligned
    rd_check("R9 unmapped read 0x44", 8'h44, 32'h0);
    rd_check("R9 unmapped read 0xFC", 8'hFC, 32'h0);
    rd_check("R9 misaligned read 0x06", 8'h06, 32'h0);
    wr(8'h06, 32'hFFFF_FFFF);
    rd_check("R9 misaligned write ignored", 8'h04, map_pat(8'h04));
    wr(8'h48, 32'hFFFF_FFFF);
    rd_check("R9 unmapped write ignored", 8'h40, map_pat(8'h40));
    rd_check("R9 unmapped stays zero", 8'h48, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule